// File: doc/BRIEF.md
# Interrupt Request Pending and Mask Bank

This block sits between 64 raw interrupt request lines and the downstream interrupt logic. On every clock edge it captures the level of each request line into a pending register. It also keeps a 64-bit mask in which a 1 blocks a source. It drives one enable line per source and a single summary line that reports whether any unmasked source is pending.

Software uses a small register bus with an address, a write strobe, write data and combinational read data. Through it, software reads both pending words and reads and writes both mask words. A single low-word write with bit 0 set masks every source at once. This gives a one-write way to shut off all interrupts.

Top module: `irq_pend_mask`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every mask bit is 1, every pending bit is 0 and `any_req_o` is 0.
- R2: `en_req_o[i]` is 1 exactly when pending bit i is 1 and mask bit i is 0. A mask bit of 1 always holds its enable line at 0.
- R3: Each clock edge copies `req_i[63:1]` into the pending register. The pending word reads and `en_req_o` show a request change after one edge, whatever the mask holds.
- R4: Pending bit 0 is always 0, whatever level `req_i[0]` has.
- R5: A write to the high mask word (address 0xC08) loads `wdata_i` into mask bits 63..32 and leaves bits 31..0 unchanged.
- R6: A write to the low mask word (address 0xC0C) with `wdata_i[0]`=1 sets all 64 mask bits to 1 at the same edge, whatever the other data bits are.
- R7: A write to the low mask word with `wdata_i[0]`=0 loads `wdata_i` into mask bits 31..0 and leaves bits 63..32 unchanged. Mask bit 0 reads back as the last value written to it.
- R8: The pending words (0xC00 high, 0xC04 low) are read-only. A write to either address changes neither the pending bits nor the mask.
- R9: `any_req_o` equals the OR of `en_req_o` as it was one clock earlier.
- R10: The register map is as follows: 0xC00 reads pending bits 63..32, 0xC04 reads pending bits 31..0, 0xC08 holds mask bits 63..32, and 0xC0C holds mask bits 31..0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Raw request level per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register address, used for both read and write |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| en_req_o | output | 64 | Per-source request, pending and not masked |
| any_req_o | output | 1 | Registered OR of `en_req_o` |

## Verification
The request lines are driven in four patterns:
- All ones while fully masked. This separates the pending path from the gated path.
- Alternating bytes under a partial mask. This catches swapped or shifted word slices.
- Only bit 0. This shows that the reserved bit is dropped.
- Only bit 63 with just that mask bit cleared. This shows the summary line works from the far end of the vector.

Mask writes are chosen in pairs: a low-word write with bit 0 set and one with bit 0 clear. Together they separate the mask-all force from an ordinary word load. They also separate a per-word update from a whole-vector update.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

  localparam int unsigned IRQ_SRC_N  = 64;
  localparam int unsigned IRQ_WORD_W = 32;
  localparam int unsigned IRQ_WORDS  = IRQ_SRC_N / IRQ_WORD_W;
  localparam int unsigned REG_STRIDE = 4;

  typedef logic [IRQ_SRC_N-1:0]  irq_vec_t;
  typedef logic [IRQ_WORD_W-1:0] irq_word_t;

  // Reserved source 0 never becomes pending.
  function automatic irq_vec_t f_capture(input irq_vec_t raw);
    irq_vec_t v;
    v    = raw;
    v[0] = 1'b0;
    return v;
  endfunction

  // A set mask bit blocks its source.
  function automatic irq_vec_t f_gate(input irq_vec_t pend, input irq_vec_t mask);
    return pend & ~mask;
  endfunction

  // Word w holds bits [w*W +: W]; the highest word sits at the base address.
  function automatic logic [11:0] f_word_addr(input logic [11:0] base, input int unsigned w);
    return base + 12'(REG_STRIDE * (IRQ_WORDS - 1 - w));
  endfunction

endpackage

// File: rtl/irq_pm_sampler.sv
module irq_pm_sampler
  import irq_pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t req_i,
  output irq_vec_t pend_o
);

  irq_vec_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= f_capture(req_i);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_pm_mask_bank.sv
module irq_pm_mask_bank
  import irq_pm_pkg::*;
#(
  parameter logic [11:0] MASK_BASE = 12'hC08
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [11:0]          addr_i,
  input  irq_word_t            wdata_i,
  output irq_vec_t             mask_o,
  output logic [IRQ_WORDS-1:0] word_hit_o,
  output logic                 mask_all_o
);

  // Word 0 is the low word; its bit 0 triggers the global mask-all.
  assign mask_all_o = word_hit_o[0] && wdata_i[0];

  for (genvar w = 0; w < IRQ_WORDS; w++) begin : g_word
    irq_word_t word_q;

    assign word_hit_o[w] = wr_en_i && (addr_i == f_word_addr(MASK_BASE, w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             word_q <= '1;
      else if (mask_all_o)    word_q <= '1;
      else if (word_hit_o[w]) word_q <= wdata_i;
    end

    assign mask_o[w*IRQ_WORD_W +: IRQ_WORD_W] = word_q;
  end

endmodule

// File: rtl/irq_pm_gate.sv
module irq_pm_gate
  import irq_pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t pend_i,
  input  irq_vec_t mask_i,
  output irq_vec_t en_o,
  output logic     any_o
);

  logic any_q;

  assign en_o = f_gate(pend_i, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= |en_o;
  end

  assign any_o = any_q;

endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask
  import irq_pm_pkg::*;
#(
  parameter logic [11:0] PEND_BASE = 12'hC00,
  parameter logic [11:0] MASK_BASE = 12'hC08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] req_i,
  input  logic        wr_en_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [63:0] en_req_o,
  output logic        any_req_o
);

  irq_vec_t             pend_q;
  irq_vec_t             mask_q;
  logic [IRQ_WORDS-1:0] mask_word_hit;
  logic                 mask_all_hit;

  irq_pm_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .pend_o (pend_q)
  );

  irq_pm_mask_bank #(.MASK_BASE(MASK_BASE)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mask_o     (mask_q),
    .word_hit_o (mask_word_hit),
    .mask_all_o (mask_all_hit)
  );

  irq_pm_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .en_o   (en_req_o),
    .any_o  (any_req_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < IRQ_WORDS; w++) begin
      if (addr_i == f_word_addr(PEND_BASE, w)) rdata_o = pend_q[w*IRQ_WORD_W +: IRQ_WORD_W];
      if (addr_i == f_word_addr(MASK_BASE, w)) rdata_o = mask_q[w*IRQ_WORD_W +: IRQ_WORD_W];
    end
  end

endmodule

// File: rtl/irq_pm_checker.sv
module irq_pm_checker
  import irq_pm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [63:0]          req_i,
  input logic [31:0]          wdata_i,
  input logic [63:0]          en_req_o,
  input logic                 any_req_o,
  input irq_vec_t             pend_q,
  input irq_vec_t             mask_q,
  input logic [IRQ_WORDS-1:0] mask_word_hit,
  input logic                 mask_all_hit
);

  // Set from the first edge after reset so $past never reaches reset values.
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_pend_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> pend_q[63:1] == $past(req_i[63:1]));

  p_pend_bit0_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] == 1'b0);

  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req_o & mask_q) == '0);

  p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all_hit |=> &mask_q);

  p_hi_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_word_hit[IRQ_WORDS-1] && !mask_all_hit) |=>
      (mask_q[31:0] == $past(mask_q[31:0])) && (mask_q[63:32] == $past(wdata_i)));

  p_any_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> any_req_o == $past(|en_req_o));

endmodule

bind irq_pend_mask irq_pm_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .wdata_i       (wdata_i),
  .en_req_o      (en_req_o),
  .any_req_o     (any_req_o),
  .pend_q        (pend_q),
  .mask_q        (mask_q),
  .mask_word_hit (mask_word_hit),
  .mask_all_hit  (mask_all_hit)
);

// File: tb/irq_pend_mask_tb.sv
module irq_pend_mask_tb;

  localparam logic [11:0] A_PHI = 12'hC00;
  localparam logic [11:0] A_PLO = 12'hC04;
  localparam logic [11:0] A_MHI = 12'hC08;
  localparam logic [11:0] A_MLO = 12'hC0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] en_req_o;
  logic        any_req_o;

  always #2 clk = ~clk;

  irq_pend_mask u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .en_req_o(en_req_o), .any_req_o(any_req_o)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 enable vector, 2 summary line
    logic [63:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;
  logic [63:0] m_mask = '1;
  logic [63:0] m_pend = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int kind, logic [63:0] exp, int due, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.due = due; it.tag = tag;
    sb.push_back(it);
  endfunction

  // Monitor: compare due items just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          logic [63:0] act;
          case (sb[i].kind)
            0:       act = {32'b0, rdata_o};
            1:       act = en_req_o;
            default: act = {63'b0, any_req_o};
          endcase
          checks++;
          if (act !== sb[i].exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", sb[i].tag, act, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr_i = a;
    push(0, {32'b0, exp}, cyc + 1, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    if (a == A_MHI) m_mask[63:32] = d;
    if (a == A_MLO) m_mask = d[0] ? '1 : {m_mask[63:32], d};
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic chk_out(input string tag);
    logic [63:0] en;
    @(negedge clk);
    en = m_pend & ~m_mask;
    push(1, en, cyc + 1, {tag, " en_req"});
    push(2, {63'b0, |en}, cyc + 2, {tag, " any_req"});
    repeat (3) @(negedge clk);
  endtask

  task automatic set_req(input logic [63:0] v, input string tag);
    logic [63:0] en;
    @(negedge clk);
    req_i  = v;
    m_pend = {v[63:1], 1'b0};
    en     = m_pend & ~m_mask;
    push(1, en, cyc + 1, {tag, " en_req"});
    push(2, {63'b0, |en}, cyc + 2, {tag, " any_req"});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R10 map
    push(2, 64'b0, cyc + 1, "R1 any_req after reset");
    rd(A_MHI, 32'hFFFF_FFFF, "R1 mask hi reset");
    rd(A_MLO, 32'hFFFF_FFFF, "R1 mask lo reset");
    rd(A_PHI, 32'h0, "R1 pend hi reset");
    rd(A_PLO, 32'h0, "R1 pend lo reset");

    // R2/R3/R4: all requests while fully masked
    set_req('1, "R2 fully masked");
    rd(A_PHI, 32'hFFFF_FFFF, "R3 pend hi while masked");
    rd(A_PLO, 32'hFFFF_FFFE, "R4 pend lo bit0 dropped");

    // R7: low write with bit0 clear
    wr(A_MLO, 32'h0000_0000);
    rd(A_MLO, 32'h0000_0000, "R7 mask lo loaded");
    rd(A_MHI, 32'hFFFF_FFFF, "R7 mask hi untouched");
    chk_out("R2 low word open");

    // R5: high write only
    wr(A_MHI, 32'h0F0F_0000);
    rd(A_MHI, 32'h0F0F_0000, "R5 mask hi loaded");
    rd(A_MLO, 32'h0000_0000, "R5 mask lo untouched");
    set_req(64'hA5A5_5A5A_C3C3_3C3D, "R3 alternating pattern");
    rd(A_PHI, 32'hA5A5_5A5A, "R3 pend hi pattern");
    rd(A_PLO, 32'hC3C3_3C3C, "R3 pend lo pattern");

    // R8: writes to pending words ignored
    wr(A_PHI, 32'h0000_0000);
    wr(A_PLO, 32'hFFFF_FFFF);
    rd(A_PHI, 32'hA5A5_5A5A, "R8 pend hi after write");
    rd(A_PLO, 32'hC3C3_3C3C, "R8 pend lo after write");
    rd(A_MHI, 32'h0F0F_0000, "R8 mask hi after pend write");
    chk_out("R8 outputs after pend write");

    // R6: mask-all
    wr(A_MLO, 32'h1234_5671);
    rd(A_MHI, 32'hFFFF_FFFF, "R6 mask hi forced");
    rd(A_MLO, 32'hFFFF_FFFF, "R6 mask lo forced");
    chk_out("R6 all blocked");

    // R7: clearing bit0 clears nothing else
    wr(A_MLO, 32'hFFFF_FFFE);
    rd(A_MLO, 32'hFFFF_FFFE, "R7 bit0 readback");
    rd(A_MHI, 32'hFFFF_FFFF, "R7 hi kept after bit0 clear");

    // R10 unmapped
    rd(12'hC10, 32'h0, "R10 unmapped read");
    rd(12'h000, 32'h0, "R10 unmapped low read");

    // R4: only source 0 requesting with bit0 unmasked
    wr(A_MLO, 32'h0000_0000);
    set_req(64'h1, "R4 only source 0");
    rd(A_PLO, 32'h0, "R4 pend lo zero");

    // R9/R2: top source only
    wr(A_MHI, 32'h7FFF_FFFF);
    set_req(64'h8000_0000_0000_0000, "R9 top source");
    wr(A_MHI, 32'hFFFF_FFFF);
    chk_out("R9 top source masked again");

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule